// File: doc/BRIEF.md
# Host UART register-set emulator

This block lets local firmware stand in for a FIFO serial port. The host bus sees the usual eight-register set of a PC-compatible FIFO UART. There is no serial line behind it. A second register port, driven by a local microprocessor, supplies the rest. Every host write that changes configuration, and every host write of a transmit byte, latches a pending request towards the local processor. The local side receives a 3-bit cause code and a level interrupt. Firmware reads the matching local register to collect the value, and that read retires the request.

In the other direction, the local processor pushes received characters into a receive FIFO, each with three error flags. It also writes the whole modem status byte. The host pops the FIFO through the receive buffer. The host interrupt is built from the receive fill level and from line status, transmit holding empty and modem status, each gated by its own enable bit.

A legacy enable on the local side turns the FIFO off, so the block behaves as a single-byte buffer port.

Top module: `host_uart_emu`

## Requirements
- R1: The receive FIFO holds DEPTH (16) entries, each with 8 data bits and 3 flags. A local write to local offset 0 pushes `l_wdata` with `l_err`, where bit 0 is parity, bit 1 is framing and bit 2 is break. A host read of offset 0, with line control bit 7 clear, returns the oldest byte and pops it. The head entry's flags appear in line status bit 2 (parity), bit 3 (framing) and bit 4 (break). Line status bit 0 is set while the FIFO is not empty.
- R2: A push into a full FIFO is dropped and sets line status bit 1. A host read of line status (offset 5) clears that bit.
- R3: FIFO control bits 7:6 set the receive trigger: 00 is 1, 01 is DEPTH/4, 10 is DEPTH/2 and 11 is DEPTH-2 characters. When interrupt enable bit 0 is set and the fill count reaches the trigger, `h_irq` asserts and the identification register reads 0xC4.
- R4: A host write of the transmit holding register raises local cause 111. A local read of local offset 0 returns the byte and retires the request. A second host write before that read replaces the byte and raises cause 001.
- R5: Host writes of FIFO control (offset 2), divisor bytes, line control (offset 3) and modem control (offset 4) raise causes 001, 010, 011 and 100. A local read of local offset 1, of offset 2 or 3, of offset 4 or of offset 5 returns that value and retires that cause. `l_cause` shows the lowest-numbered pending code, and `l_irq` is set while any code is pending.
- R6: While line control bit 7 is set, host offsets 0 and 1 read and write the divisor low and high bytes. The FIFO and the interrupt enable register are left untouched.
- R7: Writing 1 to bit 0 of local offset 2 selects legacy mode. FIFO control bit 0 then reads 0, identification bits 7:6 read 00, the FIFO capacity is 1 and line status bit 7 reads 0.
- R8: In FIFO mode, line status bit 7 is set while any stored entry carries a flag, and clears once the last such entry is popped.
- R9: The host modem status register (offset 6) is the byte last written at local offset 1. A host read of it clears bits 3:0. With interrupt enable bit 3 set, a nonzero value in bits 3:0 gives the modem interrupt, and the identification register reads 0x00 in its low nibble.
- R10: The identification register (host offset 2) reports the highest-priority source: line status 0x6, then receive data 0x4, then transmit empty 0x2, then modem 0x0. It reads 0x1 when no source is active. Bits 7:6 read 11 in FIFO mode. `h_irq` follows any active source.
- R11: Line status bits 6:5 are set while no transmit byte awaits the local side. The transmit-empty interrupt is pending after reset and after each local read of a waiting byte. It is cleared by a host write of the transmit holding register, or by a host identification read that reports it.
- R12: Each host pop raises local cause 101. A local read of local offset 7 returns the fill count and retires the cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| h_addr | input | 3 | Host register offset |
| h_wr | input | 1 | Host write strobe |
| h_rd | input | 1 | Host read strobe (pops and clears act at the edge) |
| h_wdata | input | 8 | Host write data |
| h_rdata | output | 8 | Host read data, combinational |
| h_irq | output | 1 | Host interrupt |
| l_addr | input | 3 | Local register offset |
| l_wr | input | 1 | Local write strobe |
| l_rd | input | 1 | Local read strobe |
| l_wdata | input | 8 | Local write data |
| l_err | input | 3 | Error flags stored with a pushed character |
| l_rdata | output | 8 | Local read data, combinational |
| l_irq | output | 1 | Local interrupt |
| l_cause | output | 3 | Lowest-numbered pending local cause |

## Verification
The embedded properties watch, on every cycle, that the fill count never passes the depth. They check that a push into a full FIFO leaves the count alone and raises overrun, that a transmit or line control write always raises the local interrupt, and that legacy mode never shows FIFO control bit 0 or the error summary. Only the directed scenarios show the data order through the FIFO and each trigger threshold. The same holds for the ranking of causes, the divisor redirection and the full identification priority chain, since each of these depends on a specific sequence of writes and reads.

// File: rtl/host_uart_emu.sv
module host_uart_emu #(
  parameter int DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] h_addr,
  input  logic       h_wr,
  input  logic       h_rd,
  input  logic [7:0] h_wdata,
  output logic [7:0] h_rdata,
  output logic       h_irq,
  input  logic [2:0] l_addr,
  input  logic       l_wr,
  input  logic       l_rd,
  input  logic [7:0] l_wdata,
  input  logic [2:0] l_err,
  output logic [7:0] l_rdata,
  output logic       l_irq,
  output logic [2:0] l_cause
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] CAPF = (AW+1)'(DEPTH);

  logic [10:0]   mem [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr;
  logic [AW:0]   cnt, trig;
  logic [7:0]    lcr, mcr, fcr_q, dll, dlm, msr, thr, lsr, iir;
  logic [3:0]    ier;
  logic [7:1]    pend;
  logic          legacy, thr_full, thre_pend, oe, err_any;

  wire dlab    = lcr[7];
  wire fifo_en = fcr_q[0];
  wire full    = cnt >= (fifo_en ? CAPF : (AW+1)'(1));

  wire wr_thr = h_wr && h_addr == 3'd0 && !dlab;
  wire wr_dll = h_wr && h_addr == 3'd0 &&  dlab;
  wire wr_ier = h_wr && h_addr == 3'd1 && !dlab;
  wire wr_dlm = h_wr && h_addr == 3'd1 &&  dlab;
  wire wr_fcr = h_wr && h_addr == 3'd2;
  wire wr_lcr = h_wr && h_addr == 3'd3;
  wire wr_mcr = h_wr && h_addr == 3'd4;
  wire rd_rbr = h_rd && h_addr == 3'd0 && !dlab;
  wire rd_iir = h_rd && h_addr == 3'd2;
  wire rd_lsr = h_rd && h_addr == 3'd5;
  wire rd_msr = h_rd && h_addr == 3'd6;

  wire push = l_wr && l_addr == 3'd0;
  wire do_push = push && !full;
  wire pop  = rd_rbr && cnt != '0;
  wire lr_thr = l_rd && l_addr == 3'd0;
  wire lr_fcr = l_rd && l_addr == 3'd1;
  wire lr_dl  = l_rd && (l_addr == 3'd2 || l_addr == 3'd3);
  wire lr_lcr = l_rd && l_addr == 3'd4;
  wire lr_mcr = l_rd && l_addr == 3'd5;
  wire lr_cnt = l_rd && l_addr == 3'd7;
  wire lw_leg = l_wr && l_addr == 3'd2;
  wire legacy_nx = lw_leg ? l_wdata[0] : legacy;

  wire [10:0] head = mem[rd_ptr];
  wire [2:0] head_err = (cnt != '0) ? head[10:8] : 3'b000;

  always_comb begin
    err_any = 1'b0;
    for (int k = 0; k < DEPTH; k++)
      if ({1'b0, AW'(k) - rd_ptr} < cnt && |mem[k][10:8]) err_any = 1'b1;
  end

  always_comb
    case (fcr_q[7:6])
      2'b00:   trig = (AW+1)'(1);
      2'b01:   trig = (AW+1)'(DEPTH/4);
      2'b10:   trig = (AW+1)'(DEPTH/2);
      default: trig = (AW+1)'(DEPTH-2);
    endcase

  wire ls_src = ier[2] && (oe || |head_err);
  wire rx_src = ier[0] && cnt >= trig;
  wire th_src = ier[1] && thre_pend;
  wire ms_src = ier[3] && |msr[3:0];
  assign h_irq = ls_src || rx_src || th_src || ms_src;
  wire [2:0] iid = ls_src ? 3'b011 : rx_src ? 3'b010 : th_src ? 3'b001 : 3'b000;
  assign iir = {fifo_en, fifo_en, 2'b00, iid, !h_irq};
  assign lsr = {fifo_en && err_any, !thr_full, !thr_full, head_err, oe, cnt != '0};

  always_comb
    case (h_addr)
      3'd0: h_rdata = dlab ? dll : (cnt != '0 ? head[7:0] : 8'h00);
      3'd1: h_rdata = dlab ? dlm : {4'b0, ier};
      3'd2: h_rdata = iir;
      3'd3: h_rdata = lcr;
      3'd4: h_rdata = mcr;
      3'd5: h_rdata = lsr;
      3'd6: h_rdata = msr;
      default: h_rdata = 8'h00;
    endcase

  always_comb
    case (l_addr)
      3'd0: l_rdata = thr;
      3'd1: l_rdata = fcr_q;
      3'd2: l_rdata = dll;
      3'd3: l_rdata = dlm;
      3'd4: l_rdata = lcr;
      3'd5: l_rdata = mcr;
      3'd6: l_rdata = {5'b0, l_cause};
      default: l_rdata = 8'(cnt);
    endcase

  always_comb begin
    l_cause = 3'd0;
    for (int i = 7; i >= 1; i--) if (pend[i]) l_cause = 3'(i);
  end
  assign l_irq = |pend;

  always_ff @(posedge clk)
    if (do_push) mem[wr_ptr] <= {l_err, l_wdata};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rd_ptr <= '0; wr_ptr <= '0; cnt <= '0;
      lcr <= '0; mcr <= '0; fcr_q <= '0; dll <= '0; dlm <= '0; msr <= '0;
      thr <= '0; ier <= '0; pend <= '0; legacy <= 1'b0;
      thr_full <= 1'b0; thre_pend <= 1'b1; oe <= 1'b0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + 1'b1;
      if (pop) rd_ptr <= rd_ptr + 1'b1;
      cnt <= cnt + (AW+1)'(do_push) - (AW+1)'(pop);
      if (wr_thr) thr <= h_wdata;
      if (wr_dll) dll <= h_wdata;
      if (wr_dlm) dlm <= h_wdata;
      if (wr_ier) ier <= h_wdata[3:0];
      if (wr_lcr) lcr <= h_wdata;
      if (wr_mcr) mcr <= h_wdata;
      legacy <= legacy_nx;
      if (wr_fcr) fcr_q <= {h_wdata[7:6], 5'b0, h_wdata[0] && !legacy_nx};
      else if (legacy_nx) fcr_q[0] <= 1'b0;
      if (l_wr && l_addr == 3'd1) msr <= l_wdata;
      else if (rd_msr) msr[3:0] <= 4'b0;
      if (push && full) oe <= 1'b1;
      else if (rd_lsr) oe <= 1'b0;
      thr_full <= wr_thr || (thr_full && !lr_thr);
      if (wr_thr) thre_pend <= 1'b0;
      else if (lr_thr && thr_full) thre_pend <= 1'b1;
      else if (rd_iir && h_irq && iid == 3'b001) thre_pend <= 1'b0;
      pend[7] <= wr_thr || (pend[7] && !lr_thr);
      pend[6] <= 1'b0;
      pend[5] <= pop || (pend[5] && !lr_cnt);
      pend[4] <= wr_mcr || (pend[4] && !lr_mcr);
      pend[3] <= wr_lcr || (pend[3] && !lr_lcr);
      pend[2] <= wr_dll || wr_dlm || (pend[2] && !lr_dl);
      pend[1] <= wr_fcr || (wr_thr && thr_full && !lr_thr) || (pend[1] && !lr_fcr);
    end

  assert_count_bound_R1: assert property (@(posedge clk) disable iff (!rst_n) cnt <= CAPF);
  assert_full_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> (cnt == $past(cnt) && lsr[1]));
  assert_thr_raises_irq_R4: assert property (@(posedge clk) disable iff (!rst_n) wr_thr |=> l_irq);
  assert_lcr_raises_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lcr && !lr_lcr) |=> l_irq);
  assert_legacy_no_fifo_R7: assert property (@(posedge clk) disable iff (!rst_n)
    legacy |-> (!fcr_q[0] && !lsr[7] && iir[7:6] == 2'b00));
endmodule

// File: tb/sim_host_uart_emu.sv
`timescale 1ns/100ps
module sim_host_uart_emu;
  logic clk = 0, rst_n = 0;
  logic [2:0] h_addr = 0, l_addr = 0, l_err = 0;
  logic h_wr = 0, h_rd = 0, l_wr = 0, l_rd = 0;
  logic [7:0] h_wdata = 0, l_wdata = 0, h_rdata, l_rdata, v;
  logic h_irq, l_irq;
  logic [2:0] l_cause;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  host_uart_emu u0 (.clk(clk), .rst_n(rst_n), .h_addr(h_addr), .h_wr(h_wr), .h_rd(h_rd),
    .h_wdata(h_wdata), .h_rdata(h_rdata), .h_irq(h_irq), .l_addr(l_addr), .l_wr(l_wr),
    .l_rd(l_rd), .l_wdata(l_wdata), .l_err(l_err), .l_rdata(l_rdata), .l_irq(l_irq),
    .l_cause(l_cause));

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic hwrite(logic [2:0] a, logic [7:0] d);
    @(negedge clk); h_addr = a; h_wdata = d; h_wr = 1;
    @(negedge clk); h_wr = 0; #1;
  endtask
  task automatic hread(logic [2:0] a, output logic [7:0] d);
    @(negedge clk); h_addr = a; h_rd = 1; #1; d = h_rdata;
    @(negedge clk); h_rd = 0; #1;
  endtask
  task automatic lwrite(logic [2:0] a, logic [7:0] d);
    @(negedge clk); l_addr = a; l_wdata = d; l_wr = 1;
    @(negedge clk); l_wr = 0; #1;
  endtask
  task automatic lread(logic [2:0] a, output logic [7:0] d);
    @(negedge clk); l_addr = a; l_rd = 1; #1; d = l_rdata;
    @(negedge clk); l_rd = 0; #1;
  endtask
  task automatic lpush(logic [7:0] d, logic [2:0] e);
    l_err = e; lwrite(3'd0, d); l_err = 0;
  endtask

  task automatic t_reset;
    hread(3'd5, v); chk("R11 reset line status", v, 8'h60);
    hread(3'd2, v); chk("R10 reset ident", v, 8'h01);
    chk("R4 reset local irq", {7'b0, l_irq}, 8'h00);
  endtask

  task automatic t_thr;
    hwrite(3'd0, 8'h5A); chk("R4 thr cause", {5'b0, l_cause}, 8'h07);
    hread(3'd5, v); chk("R11 thr busy", v, 8'h00);
    hwrite(3'd0, 8'hA5); chk("R4 overrun cause", {5'b0, l_cause}, 8'h01);
    lread(3'd1, v); chk("R4 cause after fcr read", {5'b0, l_cause}, 8'h07);
    lread(3'd0, v); chk("R4 thr byte", v, 8'hA5);
    chk("R4 irq retired", {7'b0, l_irq}, 8'h00);
    hread(3'd5, v); chk("R11 thr empty", v, 8'h60);
  endtask

  task automatic t_cfg;
    hwrite(3'd3, 8'h03); chk("R5 lcr cause", {5'b0, l_cause}, 8'h03);
    lread(3'd4, v); chk("R5 lcr value", v, 8'h03);
    hwrite(3'd4, 8'h0B); chk("R5 mcr cause", {5'b0, l_cause}, 8'h04);
    lread(3'd5, v); chk("R5 mcr value", v, 8'h0B);
    hwrite(3'd2, 8'hC1); chk("R5 fcr cause", {5'b0, l_cause}, 8'h01);
    lread(3'd1, v); chk("R5 fcr value", v, 8'hC1);
    hwrite(3'd1, 8'h05);
    hwrite(3'd3, 8'h83); lread(3'd4, v);
    hwrite(3'd0, 8'h0C); chk("R5 divisor cause", {5'b0, l_cause}, 8'h02);
    hwrite(3'd1, 8'h12);
    hread(3'd1, v); chk("R6 divisor high host", v, 8'h12);
    hread(3'd0, v); chk("R6 divisor low host", v, 8'h0C);
    lread(3'd3, v); chk("R6 divisor high local", v, 8'h12);
    lread(3'd2, v); chk("R6 divisor low local", v, 8'h0C);
    chk("R5 all retired", {5'b0, l_cause}, 8'h00);
    hwrite(3'd3, 8'h03); lread(3'd4, v);
    hread(3'd1, v); chk("R6 ier untouched", v, 8'h05);
    hwrite(3'd1, 8'h00);
  endtask

  task automatic t_trig(logic [1:0] code, int lvl);
    hwrite(3'd2, {code, 6'b000001}); lread(3'd1, v);
    hwrite(3'd1, 8'h01);
    for (int i = 0; i < lvl - 1; i++) lpush(8'(8'h10 + i), 3'b000);
    chk("R3 below trigger", {7'b0, h_irq}, 8'h00);
    lpush(8'(8'h10 + lvl - 1), 3'b000);
    chk("R3 at trigger", {7'b0, h_irq}, 8'h01);
    hread(3'd2, v); chk("R3 ident rx", v, 8'hC4);
    lread(3'd7, v); chk("R12 fill count", v, 8'(lvl));
    for (int i = 0; i < lvl; i++) begin
      hread(3'd0, v); chk("R1 fifo order", v, 8'(8'h10 + i));
    end
    chk("R12 pop cause", {5'b0, l_cause}, 8'h05);
    lread(3'd7, v); chk("R12 empty count", v, 8'h00);
    chk("R12 retired", {7'b0, l_irq}, 8'h00);
    hwrite(3'd1, 8'h00);
  endtask

  task automatic t_overrun;
    hwrite(3'd2, 8'hC1); lread(3'd1, v);
    for (int i = 0; i < 16; i++) lpush(8'(8'h20 + i), 3'b000);
    lpush(8'hEE, 3'b000);
    hread(3'd5, v); chk("R2 overrun flag", v, 8'h63);
    hread(3'd5, v); chk("R2 overrun cleared", v, 8'h61);
    for (int i = 0; i < 16; i++) begin
      hread(3'd0, v); chk("R2 dropped push", v, 8'(8'h20 + i));
    end
    hread(3'd5, v); chk("R1 empty status", v, 8'h60);
    lread(3'd7, v);
  endtask

  task automatic t_err;
    hwrite(3'd1, 8'h04);
    lpush(8'h41, 3'b001); lpush(8'h42, 3'b000);
    hread(3'd5, v); chk("R8 parity head", v, 8'hE5);
    hread(3'd2, v); chk("R10 ident line", v, 8'hC6);
    hread(3'd0, v); chk("R1 err byte", v, 8'h41);
    hread(3'd5, v); chk("R8 summary cleared", v, 8'h61);
    hread(3'd0, v);
    lpush(8'h43, 3'b000); lpush(8'h44, 3'b010);
    hread(3'd5, v); chk("R8 error behind head", v, 8'hE1);
    hread(3'd0, v);
    hread(3'd5, v); chk("R1 framing head", v, 8'hE9);
    hread(3'd0, v);
    lpush(8'h45, 3'b100);
    hread(3'd5, v); chk("R1 break head", v, 8'hF1);
    hread(3'd0, v); lread(3'd7, v);
    hwrite(3'd1, 8'h00);
  endtask

  task automatic t_legacy;
    lwrite(3'd2, 8'h01);
    lread(3'd1, v); chk("R7 fcr bit0 forced", v, 8'hC0);
    hread(3'd2, v); chk("R7 ident mode bits", v, 8'h01);
    hwrite(3'd2, 8'hC1); lread(3'd1, v); chk("R7 fcr write forced", v, 8'hC0);
    lpush(8'h51, 3'b001); lpush(8'h52, 3'b000);
    hread(3'd5, v); chk("R7 single slot", v, 8'h67);
    hread(3'd0, v); chk("R7 legacy byte", v, 8'h51);
    hread(3'd5, v); chk("R7 legacy empty", v, 8'h60);
    lwrite(3'd2, 8'h00);
    hwrite(3'd2, 8'hC1); lread(3'd1, v); chk("R7 fifo restored", v, 8'hC1);
    lread(3'd7, v);
  endtask

  task automatic t_modem;
    lwrite(3'd1, 8'hB1);
    hread(3'd6, v); chk("R9 modem value", v, 8'hB1);
    hread(3'd6, v); chk("R9 delta cleared", v, 8'hB0);
    hwrite(3'd1, 8'h08); lwrite(3'd1, 8'h01);
    chk("R9 modem irq", {7'b0, h_irq}, 8'h01);
    hread(3'd2, v); chk("R9 ident modem", v, 8'hC0);
    hread(3'd6, v);
    hread(3'd2, v); chk("R9 modem retired", v, 8'hC1);
    hwrite(3'd1, 8'h00);
  endtask

  task automatic t_prio;
    hwrite(3'd2, 8'h01); lread(3'd1, v);
    hwrite(3'd1, 8'h0F); lwrite(3'd1, 8'h01);
    lpush(8'h61, 3'b001);
    hread(3'd2, v); chk("R10 line first", v, 8'hC6);
    hread(3'd0, v);
    hread(3'd2, v); chk("R10 thre next", v, 8'hC2);
    hread(3'd2, v); chk("R11 thre cleared by ident", v, 8'hC0);
    hread(3'd6, v);
    hread(3'd2, v); chk("R10 none", v, 8'hC1);
    hwrite(3'd0, 8'h77);
    hread(3'd2, v); chk("R11 thre cleared by write", v, 8'hC1);
    lread(3'd0, v);
    hread(3'd2, v); chk("R11 thre after local read", v, 8'hC2);
    lread(3'd7, v); hwrite(3'd1, 8'h00);
  endtask

  initial begin
    #(5.0 * 190000);
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset; t_thr; t_cfg;
    t_trig(2'b00, 1); t_trig(2'b01, 4); t_trig(2'b10, 8); t_trig(2'b11, 14);
    t_overrun; t_err; t_legacy; t_modem; t_prio;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule